// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider

This block computes a 32-bit integer quotient over many cycles for a small processor that has no hardware divider in its execute stage. The pipeline presents two operands and a 6-bit operation code together with a one-cycle start pulse. The block then stays busy while it runs one restoring shift-and-subtract step per cycle. After the last step it pulses done and presents the quotient, which stays unchanged until the next division finishes.

One unsigned core serves both flavours. For the signed flavour, the operands are first reduced to magnitudes and the quotient sign is recorded. The core works on the magnitudes, and the sign is applied to the quotient at the end. A single shift register carries the dividend bits out at the top and takes the quotient bits in at the bottom. The partial remainder stays internal.

Top module: `idiv_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o and done_o are 0 and quo_o is 0.
- R2: A start_i pulse sampled while busy_o is low is accepted. busy_o is high from the next cycle for exactly 32 cycles. done_o is high in the cycle after the last busy cycle.
- R3: With op_sel_i equal to 6'h24, or any code other than 6'h25, the quotient is the unsigned floor of dvd_i divided by dvs_i.
- R4: With op_sel_i equal to 6'h25, both operands are two's complement. The quotient is truncated toward zero, and it is negative exactly when bit 31 of dvd_i XOR dvs_i is 1.
- R5: A zero divisor gives an unsigned magnitude of 32'hFFFFFFFF. The unsigned result is 32'hFFFFFFFF. The signed result is that magnitude, negated to 32'h00000001 when the sign bit from R4 is 1.
- R6: The most negative dividend 32'h80000000 is handled as the magnitude 2^31. Divided by -1 it gives 32'h80000000, and divided by 2 it gives 32'hC0000000.
- R7: A start_i pulse while busy_o is high is ignored. The running division keeps its timing and its result.
- R8: quo_o changes only in a cycle where done_o is high, and it holds its value between completions.
- R9: done_o is never high together with busy_o, and it is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| op_sel_i | input | 6 | Operation code: 6'h25 signed, otherwise unsigned |
| dvd_i | input | 32 | Dividend |
| dvs_i | input | 32 | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quo_o | output | 32 | Quotient, held until the next completion |

## Verification
The embedded properties assume that start_i and the operands are driven cleanly between clock edges and are at known values after reset. They also assume that the operands need to be valid only in the cycle where start is sampled while idle. The stimulus changes inputs only on the falling edge. It holds start for exactly one cycle per request, except in the deliberate mid-run start test for R7, where the operands change while the block is busy. A behavioural model in the bench accepts a request only when it believes the block is idle. That model predicts busy, done and the quotient on every cycle, including back-to-back requests issued in the done cycle.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
    localparam int unsigned OPSEL_W   = 6;
    localparam logic [5:0]  OPC_UDIV  = 6'h24;
    localparam logic [5:0]  OPC_SDIV  = 6'h25;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } div_mode_e;
endpackage

// File: rtl/idiv_prep.sv
// Reduces operands to magnitudes and records the quotient sign.
module idiv_prep #(
    parameter int unsigned W = 32
) (
    input  idiv_pkg::div_mode_e mode_i,
    input  logic [W-1:0]        dvd_i,
    input  logic [W-1:0]        dvs_i,
    output logic [W-1:0]        dvd_mag_o,
    output logic [W-1:0]        dvs_mag_o,
    output logic                neg_o
);
    logic sgn;
    assign sgn       = (mode_i == idiv_pkg::MODE_SIGNED);
    assign dvd_mag_o = (sgn && dvd_i[W-1]) ? (~dvd_i + 1'b1) : dvd_i;
    assign dvs_mag_o = (sgn && dvs_i[W-1]) ? (~dvs_i + 1'b1) : dvs_i;
    assign neg_o     = sgn && (dvd_i[W-1] ^ dvs_i[W-1]);
endmodule

// File: rtl/idiv_step.sv
// One restoring iteration: shift {rem, acc} left, try to subtract divisor.
module idiv_step #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] acc_o
);
    logic [W:0] shifted;
    logic [W:0] diff;
    logic       fits;

    assign shifted = {rem_i, acc_i[W-1]};
    assign fits    = shifted >= {1'b0, dvs_i};
    assign diff    = shifted - {1'b0, dvs_i};
    assign rem_o   = fits ? diff[W-1:0] : shifted[W-1:0];
    assign acc_o   = {acc_i[W-2:0], fits};
endmodule

// File: rtl/idiv_fix.sv
// Applies the recorded sign to the unsigned quotient.
module idiv_fix #(
    parameter int unsigned W = 32
) (
    input  logic         neg_i,
    input  logic [W-1:0] mag_i,
    output logic [W-1:0] quo_o
);
    assign quo_o = neg_i ? (~mag_i + 1'b1) : mag_i;
endmodule

// File: rtl/idiv_seq.sv
module idiv_seq #(
    parameter int unsigned W       = 32,
    parameter int unsigned OPSEL_W = idiv_pkg::OPSEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [OPSEL_W-1:0] op_sel_i,
    input  logic [W-1:0]       dvd_i,
    input  logic [W-1:0]       dvs_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [W-1:0]       quo_o
);
    import idiv_pkg::*;

    localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             neg;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rem;
        logic [W-1:0]     acc;
        logic [W-1:0]     dvs;
        logic [W-1:0]     quo;
    } state_t;

    state_t    st_d, st_q;
    div_mode_e mode;
    logic [W-1:0] dvd_mag, dvs_mag, rem_nx, acc_nx, quo_fixed;
    logic         neg_in;

    assign mode = (op_sel_i == OPSEL_W'(OPC_SDIV)) ? MODE_SIGNED : MODE_UNSIGNED;

    idiv_prep #(.W(W)) u_prep (
        .mode_i    (mode),
        .dvd_i     (dvd_i),
        .dvs_i     (dvs_i),
        .dvd_mag_o (dvd_mag),
        .dvs_mag_o (dvs_mag),
        .neg_o     (neg_in)
    );

    idiv_step #(.W(W)) u_step (
        .rem_i (st_q.rem),
        .acc_i (st_q.acc),
        .dvs_i (st_q.dvs),
        .rem_o (rem_nx),
        .acc_o (acc_nx)
    );

    idiv_fix #(.W(W)) u_fix (
        .neg_i (st_q.neg),
        .mag_i (acc_nx),
        .quo_o (quo_fixed)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.rem = rem_nx;
            st_d.acc = acc_nx;
            if (st_q.cnt == LAST_STEP) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.quo  = quo_fixed;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.rem  = '0;
            st_d.acc  = dvd_mag;
            st_d.dvs  = dvs_mag;
            st_d.neg  = neg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign quo_o  = st_q.quo;

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R2
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));
    // R8
    quo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(quo_o));
    // R7
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && st_q.cnt != LAST_STEP) |=> (busy_o && $stable(st_q.dvs)));
    // R3
    rem_below_dvs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && st_q.dvs != '0) |-> (st_q.rem < st_q.dvs));
endmodule

// File: tb/idiv_seq_bench.sv
`timescale 1ns/1ps
module idiv_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  op_sel_i = 6'h24;
    logic [31:0] dvd_i = '0;
    logic [31:0] dvs_i = '0;
    logic        busy_o, done_o;
    logic [31:0] quo_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    idiv_seq u_idiv_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_sel_i(op_sel_i),
        .dvd_i(dvd_i), .dvs_i(dvs_i), .busy_o(busy_o), .done_o(done_o), .quo_o(quo_o)
    );

    function automatic logic [31:0] ref_quo(input logic [31:0] a, input logic [31:0] b,
                                            input logic [5:0] op);
        logic [31:0] ua, ub, uq;
        if (op == 6'h25) begin
            ua = a[31] ? -a : a;
            ub = b[31] ? -b : b;
            uq = (ub == 0) ? 32'hFFFFFFFF : ua / ub;
            return (a[31] ^ b[31]) ? -uq : uq;
        end
        return (b == 0) ? 32'hFFFFFFFF : a / b;
    endfunction

    // Behavioural model: counts busy cycles and holds the predicted result.
    bit          m_busy, m_done;
    int          m_cnt;
    logic [31:0] m_pend, m_quo;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_cnt <= 0; m_quo <= '0; m_pend <= '0;
        end else begin
            m_done <= 0;
            if (m_busy) begin
                if (m_cnt == 31) begin
                    m_busy <= 0; m_done <= 1; m_quo <= m_pend;
                end
                m_cnt <= m_cnt + 1;
            end else if (start_i) begin
                m_busy <= 1; m_cnt <= 0;
                m_pend <= ref_quo(dvd_i, dvs_i, op_sel_i);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 busy", {31'b0, busy_o}, {31'b0, m_busy});
            check("R9 done", {31'b0, done_o}, {31'b0, m_done});
            check("R8 quotient hold", quo_o, m_quo);
        end
    end

    task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic [5:0] op);
        logic [31:0] exp;
        exp = ref_quo(a, b, op);
        start_i = 1; dvd_i = a; dvs_i = b; op_sel_i = op;
        @(negedge clk);
        start_i = 0; dvd_i = $urandom; dvs_i = $urandom;
        for (int i = 0; i < 40 && !done_o; i++) @(negedge clk);
        check(tag, quo_o, exp);
    endtask

    initial begin
        #20000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", {31'b0, busy_o}, 32'd0);
        check("R1 done in reset", {31'b0, done_o}, 32'd0);
        check("R1 quo in reset", quo_o, 32'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1 quo after reset", quo_o, 32'd0);

        run_op("R3 100/7", 32'd100, 32'd7, 6'h24);
        run_op("R3 max/1", 32'hFFFFFFFF, 32'd1, 6'h24);
        run_op("R3 other code", 32'hFFFFFFD5, 32'd7, 6'h00);
        run_op("R4 -43/7", -32'sd43, 32'd7, 6'h25);
        run_op("R4 43/-7", 32'd43, -32'sd7, 6'h25);
        run_op("R4 -43/-7", -32'sd43, -32'sd7, 6'h25);
        run_op("R5 unsigned by zero", 32'd5, 32'd0, 6'h24);
        run_op("R5 signed neg by zero", -32'sd5, 32'd0, 6'h25);
        run_op("R5 signed pos by zero", 32'd5, 32'd0, 6'h25);
        run_op("R6 min/-1", 32'h80000000, 32'hFFFFFFFF, 6'h25);
        run_op("R6 min/2", 32'h80000000, 32'd2, 6'h25);
        check("R6 literal", quo_o, 32'hC0000000);

        // R7: second start mid-run must not disturb the first division
        start_i = 1; dvd_i = 32'd1000; dvs_i = 32'd10; op_sel_i = 6'h24;
        @(negedge clk);
        start_i = 0;
        repeat (5) @(negedge clk);
        start_i = 1; dvd_i = 32'd9; dvs_i = 32'd3;
        @(negedge clk);
        start_i = 0;
        for (int i = 0; i < 40 && !done_o; i++) @(negedge clk);
        check("R7 ignored start", quo_o, 32'd100);
        @(negedge clk);
        check("R7 no second run", {31'b0, busy_o}, 32'd0);

        for (int k = 0; k < 40; k++) begin
            logic [31:0] a, b;
            a = $urandom; b = (k % 3 == 0) ? ($urandom & 32'hFF) : $urandom;
            if (k % 2 == 0) run_op("R4 random signed", a, b, 6'h25);
            else            run_op("R3 random unsigned", a, b, 6'h24);
        end
        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule